// File: doc/BRIEF.md
# Key-Locked Index/Data Watchdog Timer

This block is a countdown watchdog that software reaches through a pair of byte ports: an index port that selects a register, and a data port that reads or writes the selected register. After reset the register file is sealed. A two-write key sequence on the index port unseals it. A page-select register must then be set to the watchdog page before the timer registers become visible. A separate key on the index port seals the block again.

On the watchdog page, software sets a run bit, picks whether each count is one second or one minute, writes an 8-bit count that also services the timer, and chooses whether edges on the keyboard or mouse interrupt lines reload the count. The second and minute ticks come from a prescaler on the system clock, so a simulation can use short ticks. When the count runs out while the timer is running, the block raises a reset request for a fixed number of clocks and starts counting again from the stored value.

Top module: `wdog_idx_port`

## Requirements
- R1: After reset the block is sealed, the timer is stopped, `rst_req` is low, and both ports read 0xFF.
- R2: Two index-port writes of 0x87 in a row unseal the block. An index write of any other value between them cancels the sequence. Data-port writes do not affect the sequence.
- R3: While unsealed, index 0x07 selects the page register. Its data reads back as written. Only page value 0x08 exposes the watchdog registers. On any other page they read 0xFF and writes to them are ignored.
- R4: An index write of 0xAA seals the block and clears the page register to 0. Data writes are then ignored and reads return 0xFF until the block is unsealed again.
- R5: Register 0x30 bit 0 starts the timer (1) or stops it (0). A stopped timer holds its count. The other bits read as 0.
- R6: Register 0xF5 bit 3 selects the count unit: 0 gives one count per second tick (CLKS_PER_SEC clocks), 1 gives one count per minute tick (SECS_PER_MIN second ticks). The other bits read as 0.
- R7: Writing register 0xF6 stores the reload value and loads the count at once. A write here takes priority over any reload or tick in the same cycle. Reading 0xF6 returns the remaining count.
- R8: On each unit tick while the timer runs, a count above 1 decrements. A tick that finds the count at 1 or 0 expires the timer and reloads the count from the stored value. A stored value of 0 therefore expires on every tick.
- R9: Each expiry drives `rst_req` high for PULSE_CLKS (16) clocks, starting the cycle after the expiring tick. A new expiry restarts the pulse.
- R10: When register 0xF7 bit 6 is set, a rising edge on `kbd_irq` reloads the count from the stored value.
- R11: When register 0xF7 bit 7 is set, a rising edge on `mouse_irq` reloads the count from the stored value. Register 0xF7 bits 5:0 read as 0, and a line whose bit is clear has no effect.
- R12: On the watchdog page, indices other than 0x07, 0x30, 0xF5, 0xF6 and 0xF7 read 0xFF. While unsealed, the index port reads back the current index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Port select: 0 = index port, 1 = data port |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the port selected by `bus_sel` |
| kbd_irq | input | 1 | Keyboard interrupt line (rising edge is the event) |
| mouse_irq | input | 1 | Mouse interrupt line (rising edge is the event) |
| rst_req | output | 1 | Reset request pulse on expiry |

## Verification
The assertions check these rules on every cycle:
- the block is unsealed only by a 0x87 index write;
- sealed data writes leave every setting unchanged;
- a stopped timer holds its count;
- a reset request starts only when the timer was running, and it lasts more than one cycle;
- an enabled keyboard edge reloads the stored value.

Only the bench scenarios can show the following, which a behavioural model tracks and compares on every clock:
- an aborted key sequence;
- the effect of the wrong page number;
- minute-based counting;
- the exact pulse length and expiry cycle;
- the zero-value repeated expiry;
- interrupt lines whose enable bits are clear.

// File: rtl/wdog_idx_port.sv
module wdog_idx_port #(
  parameter int CLKS_PER_SEC = 20,
  parameter int SECS_PER_MIN = 60,
  parameter int PULSE_CLKS   = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bus_sel,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  output logic [7:0] bus_rdata,
  input  logic       kbd_irq,
  input  logic       mouse_irq,
  output logic       rst_req
);
  localparam int SW = (CLKS_PER_SEC > 1) ? $clog2(CLKS_PER_SEC) : 1;
  localparam int MW = (SECS_PER_MIN > 1) ? $clog2(SECS_PER_MIN) : 1;
  localparam int PW = $clog2(PULSE_CLKS + 1);
  localparam logic [7:0] KEY_OPEN = 8'h87, KEY_SEAL = 8'hAA, IX_PAGE = 8'h07, WD_PAGE = 8'h08;
  localparam logic [7:0] IX_EN = 8'h30, IX_UNIT = 8'hF5, IX_TMR = 8'hF6, IX_SRC = 8'hF7;

  logic          unl_q, key_q, en_q, unit_q, kbd_en_q, mse_en_q, kbd_q, mse_q;
  logic [7:0]    idx_q, page_q, tmr_q, cnt_q;
  logic [SW-1:0] sec_q;
  logic [MW-1:0] min_q;
  logic [PW-1:0] pulse_q;

  wire idx_wr   = bus_wr && !bus_sel;
  wire dat_wr   = bus_wr && bus_sel && unl_q;
  wire on_page  = page_q == WD_PAGE;
  wire reg_wr   = dat_wr && on_page;
  wire wr_tmr   = reg_wr && idx_q == IX_TMR;
  wire sec_tick = sec_q == SW'(CLKS_PER_SEC - 1);
  wire min_tick = sec_tick && min_q == MW'(SECS_PER_MIN - 1);
  wire tick     = unit_q ? min_tick : sec_tick;
  wire reload   = (kbd_irq && !kbd_q && kbd_en_q) || (mouse_irq && !mse_q && mse_en_q);
  wire expire   = !wr_tmr && !reload && tick && en_q && cnt_q <= 8'd1;

  assign rst_req = pulse_q != '0;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sec_q <= '0;
      min_q <= '0;
    end else begin
      sec_q <= sec_tick ? '0 : sec_q + 1'b1;
      if (sec_tick) min_q <= min_tick ? '0 : min_q + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      unl_q  <= 1'b0;
      key_q  <= 1'b0;
      idx_q  <= '0;
      page_q <= '0;
    end else if (idx_wr) begin
      if (!unl_q) begin
        key_q <= bus_wdata == KEY_OPEN && !key_q;
        unl_q <= bus_wdata == KEY_OPEN && key_q;
      end else if (bus_wdata == KEY_SEAL) begin
        unl_q  <= 1'b0;
        key_q  <= 1'b0;
        idx_q  <= '0;
        page_q <= '0;
      end else begin
        idx_q <= bus_wdata;
      end
    end else if (dat_wr && idx_q == IX_PAGE) begin
      page_q <= bus_wdata;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q     <= 1'b0;
      unit_q   <= 1'b0;
      kbd_en_q <= 1'b0;
      mse_en_q <= 1'b0;
      tmr_q    <= '0;
    end else if (reg_wr) begin
      case (idx_q)
        IX_EN:   en_q <= bus_wdata[0];
        IX_UNIT: unit_q <= bus_wdata[3];
        IX_TMR:  tmr_q <= bus_wdata;
        IX_SRC:  {mse_en_q, kbd_en_q} <= bus_wdata[7:6];
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      pulse_q <= '0;
      kbd_q   <= 1'b0;
      mse_q   <= 1'b0;
    end else begin
      kbd_q <= kbd_irq;
      mse_q <= mouse_irq;
      if (wr_tmr)               cnt_q <= bus_wdata;
      else if (reload || expire) cnt_q <= tmr_q;
      else if (tick && en_q)    cnt_q <= cnt_q - 8'd1;
      if (expire)               pulse_q <= PW'(PULSE_CLKS);
      else if (rst_req)         pulse_q <= pulse_q - 1'b1;
    end

  always_comb begin
    bus_rdata = 8'hFF;
    if (unl_q) begin
      if (!bus_sel) bus_rdata = idx_q;
      else if (idx_q == IX_PAGE) bus_rdata = page_q;
      else if (on_page)
        case (idx_q)
          IX_EN:   bus_rdata = {7'd0, en_q};
          IX_UNIT: bus_rdata = {4'd0, unit_q, 3'd0};
          IX_TMR:  bus_rdata = cnt_q;
          IX_SRC:  bus_rdata = {mse_en_q, kbd_en_q, 6'd0};
          default: bus_rdata = 8'hFF;
        endcase
    end
  end

  p_unlock_key_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(unl_q) |-> $past(bus_wr && !bus_sel && bus_wdata == KEY_OPEN));
  p_sealed_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!unl_q && bus_wr && bus_sel) |=> $stable({en_q, unit_q, kbd_en_q, mse_en_q, tmr_q}));
  p_stopped_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_q && !wr_tmr && !reload) |=> $stable(cnt_q));
  p_fire_running_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |-> $past(en_q));
  p_pulse_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_req) |=> rst_req);
  p_kbd_reload_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (kbd_irq && !kbd_q && kbd_en_q && !wr_tmr) |=> cnt_q == $past(tmr_q));
endmodule

// File: tb/wdog_idx_port_test.sv
module wdog_idx_port_test;
  localparam int CPS = 10, SPM = 4, PUL = 16;
  logic clk = 1'b0, rst_n, bus_sel = 1'b0, bus_wr = 1'b0, kbd_irq = 1'b0, mouse_irq = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic rst_req;
  int vectors = 0, errors = 0;
  string tag = "R1";
  bit go = 1'b0;

  wdog_idx_port #(.CLKS_PER_SEC(CPS), .SECS_PER_MIN(SPM), .PULSE_CLKS(PUL)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .kbd_irq(kbd_irq), .mouse_irq(mouse_irq), .rst_req(rst_req));

  always #4 clk = ~clk;

  // behavioural reference
  bit m_unl, m_key, m_en, m_unit, m_ke, m_me, m_kq, m_mq;
  int m_idx, m_page, m_tmr, m_cnt, m_sc, m_mc, m_pul;

  function automatic int m_rd();
    if (!m_unl) return 255;
    if (!bus_sel) return m_idx;
    if (m_idx == 7) return m_page;
    if (m_page != 8) return 255;
    case (m_idx)
      'h30: return m_en;
      'hF5: return m_unit ? 8 : 0;
      'hF6: return m_cnt;
      'hF7: return (m_me ? 128 : 0) + (m_ke ? 64 : 0);
      default: return 255;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_unl = 0; m_key = 0; m_en = 0; m_unit = 0; m_ke = 0; m_me = 0; m_kq = 0; m_mq = 0;
      m_idx = 0; m_page = 0; m_tmr = 0; m_cnt = 0; m_sc = 0; m_mc = 0; m_pul = 0;
    end else begin
      bit ts, tm, tk, kev, mev, wt, rl, ex, regw;
      ts = (m_sc == CPS - 1);
      tm = ts && (m_mc == SPM - 1);
      tk = m_unit ? tm : ts;
      m_sc = ts ? 0 : m_sc + 1;
      if (ts) m_mc = tm ? 0 : m_mc + 1;
      kev = kbd_irq && !m_kq; mev = mouse_irq && !m_mq;
      m_kq = kbd_irq; m_mq = mouse_irq;
      regw = bus_wr && bus_sel && m_unl && m_page == 8;
      wt = regw && m_idx == 'hF6;
      rl = (kev && m_ke) || (mev && m_me);
      ex = 0;
      if (wt) m_cnt = bus_wdata;
      else if (rl) m_cnt = m_tmr;
      else if (tk && m_en) begin
        if (m_cnt <= 1) begin ex = 1; m_cnt = m_tmr; end
        else m_cnt = m_cnt - 1;
      end
      if (ex) m_pul = PUL; else if (m_pul > 0) m_pul = m_pul - 1;
      if (regw) case (m_idx)
        'h30: m_en = bus_wdata[0];
        'hF5: m_unit = bus_wdata[3];
        'hF6: m_tmr = bus_wdata;
        'hF7: begin m_me = bus_wdata[7]; m_ke = bus_wdata[6]; end
        default: ;
      endcase
      if (bus_wr && !bus_sel) begin
        if (!m_unl) begin
          m_unl = (bus_wdata == 8'h87) && m_key;
          m_key = (bus_wdata == 8'h87) && !m_key;
        end else if (bus_wdata == 8'hAA) begin
          m_unl = 0; m_key = 0; m_idx = 0; m_page = 0;
        end else m_idx = bus_wdata;
      end else if (bus_wr && m_unl && m_idx == 7) m_page = bus_wdata;
    end
  end

  always @(negedge clk) if (go) begin
    vectors++;
    if (bus_rdata !== 8'(m_rd()) || rst_req !== (m_pul > 0)) begin
      errors++;
      $display("FAIL %s: rdata=%02h rst_req=%b expected rdata=%02h rst_req=%b",
               tag, bus_rdata, rst_req, 8'(m_rd()), m_pul > 0);
    end
  end

  task automatic chk(string t, int got, int exp);
    vectors++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got %0h expected %0h", t, got, exp);
    end
  endtask

  task automatic wr(bit s, int d);
    bus_sel = s; bus_wdata = 8'(d); bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic wreg(int i, int d);
    wr(0, i); wr(1, d);
  endtask

  task automatic rd(int i, string t, int exp);
    wr(0, i); bus_sel = 1'b1;
    @(negedge clk) chk(t, bus_rdata, exp);
    @(posedge clk); #1;
  endtask

  task automatic open_page();
    wr(0, 'h87); wr(0, 'h87); wreg('h07, 'h08);
  endtask

  task automatic pulse_kbd(bit mouse);
    if (mouse) mouse_irq = 1'b1; else kbd_irq = 1'b1;
    idle(2);
    mouse_irq = 1'b0; kbd_irq = 1'b0;
  endtask

  initial begin
    #(8 * 150000);
    errors++;
    $display("FAIL watchdog: run hung");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    int hi;
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1; go = 1'b1;
    tag = "R1";
    @(negedge clk) chk("R1", bus_rdata, 'hFF);
    chk("R1", rst_req, 0);
    @(posedge clk); #1;

    tag = "R2";
    wr(0, 'h87); wr(0, 'h11); wr(0, 'h87); wr(1, 'h00);
    bus_sel = 1'b0; @(negedge clk) chk("R2 aborted", bus_rdata, 'hFF);
    @(posedge clk); #1;
    wr(0, 'h87); wr(1, 'h55); wr(0, 'h87);
    rd('h42, "R2 unlocked", 'hFF);
    bus_sel = 1'b0; @(negedge clk) chk("R12 index readback", bus_rdata, 'h42);
    @(posedge clk); #1;

    tag = "R3";
    rd('h30, "R3 no page", 'hFF);
    wreg('h07, 'h05);
    rd('h07, "R3 page rb", 'h05);
    wreg('hF6, 'h33);
    wreg('h07, 'h08);
    rd('hF6, "R3 ignored off page", 'h00);
    rd('h30, "R3 page open", 'h00);

    tag = "R12";
    rd('h55, "R12 unimpl", 'hFF);

    tag = "R7";
    wreg('hF6, 3);
    rd('hF6, "R7 timer rb", 3);
    tag = "R6";
    wreg('hF5, 'hFF);
    rd('hF5, "R6 unit rb", 'h08);
    wreg('hF5, 'h00);

    tag = "R9";
    wreg('h30, 'h01);
    rd('h30, "R5 enable rb", 1);
    hi = 0;
    for (int i = 0; i < 200 && !rst_req; i++) @(negedge clk);
    while (rst_req) begin hi++; @(negedge clk); end
    chk("R9 pulse len", hi, PUL);
    #1;
    tag = "R5";
    wreg('h30, 'h00);
    wr(0, 'hF6); bus_sel = 1'b1;
    idle(40);
    tag = "R8";
    wreg('h30, 'h01);
    idle(80);

    tag = "R8";
    wreg('hF6, 0);
    idle(60);

    tag = "R10";
    wreg('hF6, 2);
    wreg('hF7, 'h40);
    for (int i = 0; i < 8; i++) begin pulse_kbd(0); idle(10); chk("R10 no expiry", rst_req, 0); end

    tag = "R11";
    wreg('hF7, 'h80);
    rd('hF7, "R11 src rb", 'h80);
    for (int i = 0; i < 8; i++) begin pulse_kbd(1); idle(10); chk("R11 no expiry", rst_req, 0); end
    for (int i = 0; i < 4; i++) begin pulse_kbd(0); idle(10); end

    tag = "R6";
    wreg('hF7, 'h00);
    wreg('hF5, 'h08);
    wreg('hF6, 1);
    idle(2 * CPS * SPM + 20);
    wreg('hF5, 'h00);

    tag = "R4";
    wreg('h30, 'h00);
    wr(0, 'hAA);
    wr(1, 'h01);
    rd('h30, "R4 sealed read", 'hFF);
    wr(0, 'h87); wr(0, 'h87);
    rd('h30, "R4 page cleared", 'hFF);
    wreg('h07, 'h08);
    rd('h30, "R4 write ignored", 'h00);
    open_page();
    idle(5);

    go = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule